// File: doc/BRIEF.md
# Flyback Capacitor Charge Sequencer

This block is the digital controller for a flyback converter that charges a high-voltage storage capacitor. It turns the power switch on and off, decides when each off interval ends, stops switching once the output has reached its target, and shows that state on an active-low done line. The analog comparators (primary current limit, switch-node valley detector, low-output flag and output-trip comparator), the supply-good flag and the two control pins all arrive as asynchronous digital inputs and are resynchronised inside.

A charge cycle is armed only by a fresh rising edge of the enable pin while the supply is good. A programmable start delay follows. The converter then alternates on and off phases. An on phase ends on current limit or on its own timeout. While the output is still low, each off phase is a fixed soft-start interval. After that, the next on phase starts on a valley event or when the off timeout expires. The trip comparator is only heard during off phases, and only after a short blanking window. Once it trips, switching stops and done goes low until enable is released. A separate trigger path passes the trigger pin straight to the trigger gate output, whatever the charging state.

Top module: `flyback_charge_seq`

## Requirements
- R1: Charging arms only when the synchronised enable shows a low-to-high change while supply-good is high; if enable is already high when supply-good rises, no switching occurs until enable has been low and rises again.
- R2: The switch command first goes high exactly START_CYC+3 clock cycles after enable rises at the pin (two synchroniser stages, one edge-detect cycle, then START_CYC delay cycles).
- R3: An on phase lasts min(d+3, ON_MAX_CYC) cycles, where d is the cycle within the on phase at which current limit is asserted at the pin; with no current limit it lasts ON_MAX_CYC cycles.
- R4: While the low-output flag is set, every off phase lasts exactly OFF_MAX_CYC cycles, and valley events have no effect on it.
- R5: While the low-output flag is clear, an off phase lasts min(d+3, OFF_MAX_CYC) cycles, where d is the off-phase cycle at which the valley input is asserted at the pin.
- R6: The trip input is ignored throughout on phases and during the first BLANK_CYC cycles of each off phase. A trip seen later in an off phase ends switching and drives done_n_o low.
- R7: When a valid trip and a valley event reach the controller in the same off-phase cycle, the trip wins: no further on phase starts and done_n_o goes low.
- R8: After done, the block stays stopped with done_n_o low for as long as enable stays high, whatever the other inputs do. Releasing enable raises done_n_o three cycles later, and a new charge needs a new enable rising edge.
- R9: Enable going low, or supply-good going low, forces the switch command low within three cycles and returns the block to idle.
- R10: trig_gate_o equals trig_i at all times, combinationally and in every charging state.
- R11: Out of reset, and during any charge in progress, sw_on_o is low/driven by the phases and done_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (timing parameters count its cycles) |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en_i | input | 1 | Charge enable pin; low means standby |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| ilim_i | input | 1 | Primary current-limit comparator |
| valley_i | input | 1 | Switch-node valley / flux-reset detector |
| vlow_i | input | 1 | Output still below the soft-start threshold |
| trip_i | input | 1 | Output target-voltage comparator |
| trig_i | input | 1 | Flash trigger pin |
| sw_on_o | output | 1 | Power switch gate command |
| done_n_o | output | 1 | Active-low charge-complete indicator |
| trig_gate_o | output | 1 | Trigger gate output |

## Verification
The two off-phase decisions that can fall in the same cycle are the trip that ends the charge and the valley event that starts the next on phase. The bench raises trip and valley together at a chosen off-phase cycle past the blanking window, so both reach the controller on the same edge. It then expects done_n_o low exactly three samples later, with sw_on_o never rising again. The bench also holds trip high through a whole on phase and into the blanking window, which checks that the same comparator is not heard too early.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_ON   = 3'd2,
    ST_OFF  = 3'd3,
    ST_DONE = 3'd4
  } fcs_state_e;

  // bit positions inside the synchronised input bundle
  localparam int unsigned SI_EN     = 0;
  localparam int unsigned SI_OK     = 1;
  localparam int unsigned SI_ILIM   = 2;
  localparam int unsigned SI_VALLEY = 3;
  localparam int unsigned SI_VLOW   = 4;
  localparam int unsigned SI_TRIP   = 5;
  localparam int unsigned SI_COUNT  = 6;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // a phase of lim cycles ends on the edge where the counter shows lim-1
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  function automatic logic in_blank(input int unsigned cnt, input int unsigned blank);
    return cnt < blank;
  endfunction

endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[i];
        stable_q <= meta_q;
      end
    end
    assign sync_o[i] = stable_q;
  end

endmodule

// File: rtl/fcs_arm.sv
module fcs_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic ok_s,
  output logic arm,
  output logic abort
);

  logic en_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev_q <= 1'b0;
    else        en_prev_q <= en_s;
  end

  assign arm   = en_s & ~en_prev_q & ok_s;
  assign abort = ~en_s | ~ok_s;

endmodule

// File: rtl/fcs_phase_ctrl.sv
module fcs_phase_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned START_CYC   = 200,
  parameter int unsigned ON_MAX_CYC  = 180,
  parameter int unsigned OFF_MAX_CYC = 180,
  parameter int unsigned BLANK_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       abort,
  input  logic       ilim_s,
  input  logic       valley_s,
  input  logic       vlow_s,
  input  logic       trip_s,
  output fcs_state_e state_o
);

  localparam int unsigned MAX_T = max3(START_CYC, ON_MAX_CYC, OFF_MAX_CYC);
  localparam int unsigned CW    = $clog2(MAX_T + 1);

  fcs_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr;

  // named internal events, visible to the assertions
  logic start_due, on_end, off_timeout, off_end, blank_win, trip_ok;

  assign start_due   = at_limit(32'(cnt_q), START_CYC);
  assign on_end      = ilim_s | at_limit(32'(cnt_q), ON_MAX_CYC);
  assign off_timeout = at_limit(32'(cnt_q), OFF_MAX_CYC);
  assign off_end     = vlow_s ? off_timeout : (valley_s | off_timeout);
  assign blank_win   = in_blank(32'(cnt_q), BLANK_CYC);
  assign trip_ok     = trip_s & ~blank_win;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: if (arm)       begin st_d = ST_WAIT; cnt_clr = 1'b1; end
      ST_WAIT: if (start_due) begin st_d = ST_ON;   cnt_clr = 1'b1; end
      ST_ON:   if (on_end)    begin st_d = ST_OFF;  cnt_clr = 1'b1; end
      ST_OFF: begin
        if (trip_ok)      st_d = ST_DONE;
        else if (off_end) begin st_d = ST_ON; cnt_clr = 1'b1; end
      end
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d    = ST_IDLE;
      cnt_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_clr)
        cnt_q <= '0;
      else if (st_q == ST_WAIT || st_q == ST_ON || st_q == ST_OFF)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = st_q;

  p_idle_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !arm) |=> st_q == ST_IDLE);

  p_ilim_ends_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && ilim_s && !abort) |=> st_q == ST_OFF);

  p_vlow_holds_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && vlow_s && !trip_ok && !abort && !off_timeout) |=> st_q == ST_OFF);

  p_blank_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && blank_win) |=> st_q != ST_DONE);

  p_trip_beats_valley_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && trip_s && valley_s && !blank_win && !abort) |=> st_q == ST_DONE);

  p_abort_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st_q == ST_IDLE);

endmodule

// File: rtl/flyback_charge_seq.sv
module flyback_charge_seq
  import fcs_pkg::*;
#(
  parameter int unsigned START_CYC   = 200,
  parameter int unsigned ON_MAX_CYC  = 180,
  parameter int unsigned OFF_MAX_CYC = 180,
  parameter int unsigned BLANK_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_en_i,
  input  logic supply_ok_i,
  input  logic ilim_i,
  input  logic valley_i,
  input  logic vlow_i,
  input  logic trip_i,
  input  logic trig_i,
  output logic sw_on_o,
  output logic done_n_o,
  output logic trig_gate_o
);

  logic [SI_COUNT-1:0] raw_in, syn_in;
  logic       arm, abort;
  fcs_state_e state;

  always_comb begin
    raw_in            = '0;
    raw_in[SI_EN]     = chg_en_i;
    raw_in[SI_OK]     = supply_ok_i;
    raw_in[SI_ILIM]   = ilim_i;
    raw_in[SI_VALLEY] = valley_i;
    raw_in[SI_VLOW]   = vlow_i;
    raw_in[SI_TRIP]   = trip_i;
  end

  fcs_sync #(.WIDTH(SI_COUNT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  fcs_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .en_s  (syn_in[SI_EN]),
    .ok_s  (syn_in[SI_OK]),
    .arm   (arm),
    .abort (abort)
  );

  fcs_phase_ctrl #(
    .START_CYC   (START_CYC),
    .ON_MAX_CYC  (ON_MAX_CYC),
    .OFF_MAX_CYC (OFF_MAX_CYC),
    .BLANK_CYC   (BLANK_CYC)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .abort    (abort),
    .ilim_s   (syn_in[SI_ILIM]),
    .valley_s (syn_in[SI_VALLEY]),
    .vlow_s   (syn_in[SI_VLOW]),
    .trip_s   (syn_in[SI_TRIP]),
    .state_o  (state)
  );

  assign sw_on_o     = (state == ST_ON);
  assign done_n_o    = (state != ST_DONE);
  assign trig_gate_o = trig_i;

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_in[SI_EN] |=> done_n_o);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n_o |-> !sw_on_o);

endmodule

// File: tb/tb_flyback_charge_seq.sv
module tb_flyback_charge_seq;

  localparam int START = 50;
  localparam int ONMX  = 40;
  localparam int OFFMX = 40;
  localparam int BLNK  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ok = 0, ilim = 0, valley = 0, vlow = 0, trip = 0, trig = 0;
  logic sw_on, done_n, trig_gate;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flyback_charge_seq #(
    .START_CYC(START), .ON_MAX_CYC(ONMX), .OFF_MAX_CYC(OFFMX), .BLANK_CYC(BLNK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chg_en_i(en), .supply_ok_i(ok), .ilim_i(ilim),
    .valley_i(valley), .vlow_i(vlow), .trip_i(trip), .trig_i(trig),
    .sw_on_o(sw_on), .done_n_o(done_n), .trig_gate_o(trig_gate)
  );

  function automatic int exp_on(input int d);
    return (d + 3 < ONMX) ? d + 3 : ONMX;
  endfunction

  function automatic int exp_off(input int d, input bit low, input bit use_valley);
    if (low || !use_valley) return OFFMX;
    return (d + 3 < OFFMX) ? d + 3 : OFFMX;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic poke_trig();
    trig = 1'($urandom_range(0, 1));
    #1;
    chk(trig_gate == trig, "R10", int'(trig_gate), int'(trig));
  endtask

  // raise enable and return number of samples until the switch turns on
  task automatic start_charge(output int lat);
    lat = 0;
    en = 1'b1;
    while (!sw_on && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // called at the first sample of an on phase; returns at first off sample
  task automatic run_on(input int d, input bit trip_in_on, output int width);
    width = 0;
    if (d == 0) ilim = 1'b1;
    if (trip_in_on) trip = 1'b1;
    while (sw_on && width < 1000) begin
      @(negedge clk);
      width++;
      if (width == d) ilim = 1'b1;
      if (sw_on) chk(done_n == 1'b1, "R11", int'(done_n), 1);
    end
    ilim = 1'b0;
    trip = 1'b0;
  endtask

  // called at the first sample of an off phase; returns at first on sample
  task automatic run_off(input int d, input bit use_valley, output int width);
    width = 0;
    if (use_valley && d == 0) valley = 1'b1;
    while (!sw_on && done_n && width < 1000) begin
      @(negedge clk);
      width++;
      if (use_valley && width == d) valley = 1'b1;
    end
    valley = 1'b0;
  endtask

  task automatic release_enable();
    en = 1'b0;
    ticks(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, w, d;
    bit uv;
    void'($urandom(32'd20240611));

    ticks(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw_on == 1'b0, "R11 reset sw", int'(sw_on), 0);
    chk(done_n == 1'b1, "R11 reset done", int'(done_n), 1);
    poke_trig();

    // R1: enable already high when supply becomes good
    en = 1'b1;
    ticks(20);
    ok = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < START + 60; i++) begin
        @(negedge clk);
        if (sw_on) seen++;
      end
      chk(seen == 0, "R1 no start without fresh edge", seen, 0);
    end
    release_enable();

    // R2 start latency, then soft-start phases (R3, R4)
    vlow = 1'b1;
    start_charge(lat);
    chk(lat == START + 3, "R2 start latency", lat, START + 3);
    for (int k = 0; k < 4; k++) begin
      d = int'($urandom_range(0, ONMX + 5));
      uv = 1'($urandom_range(0, 1));
      run_on(d, uv, w);
      chk(w == exp_on(d), "R3 on width", w, exp_on(d));
      poke_trig();
      d = int'($urandom_range(0, 20));
      run_off(d, 1'b1, w);
      chk(w == exp_off(d, 1'b1, 1'b1), "R4 fixed off width", w, exp_off(d, 1'b1, 1'b1));
    end

    // R5: valley-driven off phases, including trip during on (R6)
    vlow = 1'b0;
    d = int'($urandom_range(0, 10));
    run_on(d, 1'b0, w);
    chk(w == exp_on(d), "R3 on width", w, exp_on(d));
    run_off(OFFMX, 1'b0, w);
    chk(w == OFFMX, "R5 off timeout", w, OFFMX);
    for (int k = 0; k < 8; k++) begin
      d = int'($urandom_range(0, ONMX + 5));
      uv = 1'($urandom_range(0, 1));
      run_on(d, uv, w);
      chk(w == exp_on(d), "R3 on width", w, exp_on(d));
      chk(done_n == 1'b1, "R6 trip ignored in on/blank", int'(done_n), 1);
      poke_trig();
      d = int'($urandom_range(0, OFFMX + 5));
      run_off(d, 1'b1, w);
      chk(w == exp_off(d, 1'b0, 1'b1), "R5 valley off width", w, exp_off(d, 1'b0, 1'b1));
    end

    // R7: trip and valley arrive together in the off phase
    run_on(0, 1'b0, w);
    ticks(1);
    trip = 1'b1;
    valley = 1'b1;
    begin
      int ons = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (sw_on) ons++;
      end
      chk(done_n == 1'b0 && ons == 0, "R7 trip wins over valley", int'(done_n), 0);
    end

    // R8: done holds while enable stays high
    begin
      int ons = 0, rel = 0;
      for (int i = 0; i < 100; i++) begin
        ilim = 1'($urandom_range(0, 1));
        valley = 1'($urandom_range(0, 1));
        trip = 1'($urandom_range(0, 1));
        @(negedge clk);
        if (sw_on) ons++;
        if (done_n) rel++;
      end
      chk(ons == 0 && rel == 0, "R8 done persists", ons + rel, 0);
    end
    poke_trig();
    ilim = 0; valley = 0; trip = 0;
    en = 1'b0;
    ticks(2);
    chk(done_n == 1'b0, "R8 done before release", int'(done_n), 0);
    ticks(1);
    chk(done_n == 1'b1, "R8 done released", int'(done_n), 1);
    ticks(4);

    // R6: trip held high into the blanking window
    vlow = 1'b1;
    start_charge(lat);
    chk(lat == START + 3, "R2 restart latency", lat, START + 3);
    ilim = 1'b1;
    @(negedge clk);
    trip = 1'b1;
    while (sw_on) @(negedge clk);
    ilim = 1'b0;
    for (int i = 1; i <= BLNK; i++) begin
      @(negedge clk);
      chk(done_n == 1'b1, "R6 blanked trip", int'(done_n), 1);
    end
    @(negedge clk);
    chk(done_n == 1'b0, "R6 trip after blank", int'(done_n), 0);
    trip = 1'b0;
    release_enable();

    // R9: enable drop in the middle of an on phase
    start_charge(lat);
    en = 1'b0;
    ticks(3);
    chk(sw_on == 1'b0, "R9 enable abort", int'(sw_on), 0);
    begin
      int ons = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (sw_on) ons++;
      end
      chk(ons == 0, "R9 stays idle", ons, 0);
    end

    // R9: supply loss, then supply back with enable still high (R1)
    start_charge(lat);
    chk(lat == START + 3, "R2 latency", lat, START + 3);
    ok = 1'b0;
    ticks(3);
    chk(sw_on == 1'b0, "R9 supply abort", int'(sw_on), 0);
    ok = 1'b1;
    begin
      int ons = 0;
      for (int i = 0; i < START + 60; i++) begin
        @(negedge clk);
        if (sw_on) ons++;
      end
      chk(ons == 0, "R1 no restart after supply return", ons, 0);
    end
    chk(done_n == 1'b1, "R11 idle done high", int'(done_n), 1);
    poke_trig();
    release_enable();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule